// File: doc/BRIEF.md
# Traffic light sequencer

This block is a synchronous Moore controller for a single road signal. Its state register holds the lamp pattern itself, one bit each for red, amber and green. The lamp outputs therefore come straight from flip-flops with no decoding stage. In the basic build the signal steps through red, red plus amber, green, amber and back to red. The sequence moves one step on each clock where the advance enable is high.

A build-time parameter selects an extended variant. That variant adds a fourth state bit that toggles on every step, so that red and green each last two steps and the cycle has six states. In either variant the next-state logic is built so that any code outside the legal cycle lands on a legal state at the first step.

A seed port loads an arbitrary raw code into the state register. It stands in for an unknown power-up value, so that recovery from every code can be exercised.

Top module: `signal_sequencer`

## Requirements
- R1: When `rst` is high at a clock edge, the state becomes red after that edge: lamps R=1, A=0, G=0, and the hidden toggle bit is 0 in the extended variant. This holds whatever `seedLoad` and `advance` are doing in that cycle.
- R2: In a cycle with `rst`, `seedLoad` and `advance` all low, every state bit keeps its value, including when the held code is an unused one.
- R3: In the basic variant the state bits are ordered {R,A,G}. On each advancing clock a legal state moves 100 → 110 → 001 → 010 → 100.
- R4: In the basic variant an advancing clock maps the unused codes 000→010, 011→100, 101→110 and 111→001.
- R5: In the extended variant the state bits are ordered {R,A,G,S}. On each advancing clock a legal state moves 1000 → 1001 → 1100 → 0011 → 0010 → 0101 → 1000, so red and green are each shown for two steps.
- R6: In the extended variant an advancing clock moves any of the ten unused codes to 1000.
- R7: When `seedLoad` is high and `rst` is low, the state register takes `seedCode` at that edge, whether or not `advance` is high. `seedCode` is ordered {R,A,G} in the basic variant and {R,A,G,S} in the extended variant.
- R8: After any advancing clock with `rst` and `seedLoad` low, the state is one of the legal codes of the selected variant. The lamps then never show all off, red with green, or amber with green.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset to red, active high, highest priority |
| advance | input | 1 | Step enable; the state holds while low |
| seedLoad | input | 1 | Loads `seedCode` into the state register; wins over `advance` |
| seedCode | input | 3 (basic) / 4 (extended) | Raw state code to load, {R,A,G} or {R,A,G,S} |
| lampRed | output | 1 | Red lamp drive, taken directly from the R state bit |
| lampAmber | output | 1 | Amber lamp drive, taken directly from the A state bit |
| lampGreen | output | 1 | Green lamp drive, taken directly from the G state bit |

## Verification
Reset, a seed load and an advance step can all be requested at the same clock edge, and only one of them may act. The bench raises all three together and expects red; it also raises seed and advance together and expects the raw seed, not its successor, to appear. Both variants run side by side from the same stimulus. A reference model built from the requirement tables predicts each cycle's lamps, and these predictions are compared one clock later.

// File: rtl/sigseq_pkg.sv
package sigseq_pkg;

  // Strobes from the control decode to the state datapath; at most one is set.
  typedef struct packed {
    logic doReset;
    logic doSeed;
    logic doStep;
  } seqStrobe_t;

  // Legal lamp codes, basic variant, {R,A,G}.
  function automatic logic isLegalBasic(input logic [2:0] code);
    return (code == 3'b100) || (code == 3'b110) ||
           (code == 3'b001) || (code == 3'b010);
  endfunction

  // Legal codes, extended variant, {R,A,G,S}.
  function automatic logic isLegalExt(input logic [3:0] code);
    return (code == 4'b1000) || (code == 4'b1001) || (code == 4'b1100) ||
           (code == 4'b0011) || (code == 4'b0010) || (code == 4'b0101);
  endfunction

endpackage

// File: rtl/sigseq_ctrl.sv
module sigseq_ctrl
  import sigseq_pkg::*;
(
  input  logic       rst,
  input  logic       seedLoad,
  input  logic       advance,
  output seqStrobe_t strobe
);

  // Fixed priority: reset, then seed, then step.
  always_comb begin
    strobe.doReset = rst;
    strobe.doSeed  = !rst && seedLoad;
    strobe.doStep  = !rst && !seedLoad && advance;
  end

endmodule

// File: rtl/sigseq_next.sv
module sigseq_next
  import sigseq_pkg::*;
#(
  parameter bit EXTENDED = 1'b0,
  parameter int STATE_W  = 3
) (
  input  logic [STATE_W-1:0] cur,
  output logic [STATE_W-1:0] nxt
);

  if (EXTENDED) begin : g_ext
    logic bitR, bitA, bitG, bitS;
    logic [3:0] raw;
    assign {bitR, bitA, bitG, bitS} = cur;
    // Toggle bit splits red and green into two steps each.
    assign raw = {bitR ^ bitA,
                  (~bitS & bitG) | (bitS & bitR),
                  (bitR & bitA & ~bitS) | (bitG & bitS),
                  ~bitS};
    // Unused codes fall straight back to the first red state.
    assign nxt = isLegalExt(cur) ? raw : 4'b1000;
  end else begin : g_basic
    logic bitR, bitA, bitG;
    assign {bitR, bitA, bitG} = cur;
    // These equations also carry every unused code onto the cycle.
    assign nxt = {bitR ^ bitA, ~bitA, bitR & bitA};
    logic unusedG;
    assign unusedG = bitG;
  end

endmodule

// File: rtl/sigseq_path.sv
module sigseq_path
  import sigseq_pkg::*;
#(
  parameter bit EXTENDED = 1'b0,
  parameter int STATE_W  = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  seqStrobe_t         strobe,
  input  logic [STATE_W-1:0] seedCode,
  output logic               lampRed,
  output logic               lampAmber,
  output logic               lampGreen
);

  localparam logic [STATE_W-1:0] RED_CODE = {1'b1, {(STATE_W-1){1'b0}}};

  logic [STATE_W-1:0] stateQ;
  logic [STATE_W-1:0] stepCode;

  sigseq_next #(
    .EXTENDED(EXTENDED),
    .STATE_W (STATE_W)
  ) u_next (
    .cur(stateQ),
    .nxt(stepCode)
  );

  always_ff @(posedge clk) begin
    if (strobe.doReset)     stateQ <= RED_CODE;
    else if (strobe.doSeed) stateQ <= seedCode;
    else if (strobe.doStep) stateQ <= stepCode;
  end

  // The lamps are the top three state bits.
  assign lampRed   = stateQ[STATE_W-1];
  assign lampAmber = stateQ[STATE_W-2];
  assign lampGreen = stateQ[STATE_W-3];

  AST_RESET_RED: assert property (@(posedge clk)
    rst |=> stateQ == RED_CODE); // R1

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!strobe.doSeed && !strobe.doStep) |=> $stable(stateQ)); // R2

  AST_SEED_LOAD: assert property (@(posedge clk) disable iff (rst)
    strobe.doSeed |=> stateQ == $past(seedCode)); // R7

  if (EXTENDED) begin : g_astExt
    AST_STEP_LEGAL: assert property (@(posedge clk) disable iff (rst)
      strobe.doStep |=> isLegalExt(stateQ)); // R8
    AST_RED_HOLD: assert property (@(posedge clk) disable iff (rst)
      (strobe.doStep && stateQ == 4'b1000) |=> stateQ == 4'b1001); // R5
  end else begin : g_astBasic
    AST_STEP_LEGAL: assert property (@(posedge clk) disable iff (rst)
      strobe.doStep |=> isLegalBasic(stateQ)); // R8
    AST_RED_TO_REDAMBER: assert property (@(posedge clk) disable iff (rst)
      (strobe.doStep && stateQ == 3'b100) |=> stateQ == 3'b110); // R3
  end

endmodule

// File: rtl/signal_sequencer.sv
module signal_sequencer
  import sigseq_pkg::*;
#(
  parameter  bit EXTENDED = 1'b0,
  localparam int STATE_W  = EXTENDED ? 4 : 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               advance,
  input  logic               seedLoad,
  input  logic [STATE_W-1:0] seedCode,
  output logic               lampRed,
  output logic               lampAmber,
  output logic               lampGreen
);

  seqStrobe_t strobe;

  sigseq_ctrl u_ctrl (
    .rst     (rst),
    .seedLoad(seedLoad),
    .advance (advance),
    .strobe  (strobe)
  );

  sigseq_path #(
    .EXTENDED(EXTENDED),
    .STATE_W (STATE_W)
  ) u_path (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .seedCode (seedCode),
    .lampRed  (lampRed),
    .lampAmber(lampAmber),
    .lampGreen(lampGreen)
  );

endmodule

// File: tb/signal_sequencer_tb.sv
`timescale 1ns/1ps
module signal_sequencer_tb;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst, advance, seedLoad;
  logic [3:0] seedCode;
  logic       bR, bA, bG, eR, eA, eG;

  signal_sequencer #(.EXTENDED(1'b0)) u_dut (
    .clk(clk), .rst(rst), .advance(advance), .seedLoad(seedLoad),
    .seedCode(seedCode[3:1]), .lampRed(bR), .lampAmber(bA), .lampGreen(bG));

  signal_sequencer #(.EXTENDED(1'b1)) u_dutExt (
    .clk(clk), .rst(rst), .advance(advance), .seedLoad(seedLoad),
    .seedCode(seedCode), .lampRed(eR), .lampAmber(eA), .lampGreen(eG));

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [3:0] modelB, modelE;
  logic [2:0] expB[$];
  logic [2:0] expE[$];
  string      tagQ[$];

  // Successor tables for R3 and R4, state in bits [3:1].
  function automatic logic [3:0] basicNext(input logic [3:0] c);
    case (c[3:1])
      3'b100: return 4'b1100;
      3'b110: return 4'b0010;
      3'b001: return 4'b0100;
      3'b010: return 4'b1000;
      3'b000: return 4'b0100;
      3'b011: return 4'b1000;
      3'b101: return 4'b1100;
      default: return 4'b0010;
    endcase
  endfunction

  // Successor tables for R5 and R6.
  function automatic logic [3:0] extNext(input logic [3:0] c);
    case (c)
      4'b1000: return 4'b1001;
      4'b1001: return 4'b1100;
      4'b1100: return 4'b0011;
      4'b0011: return 4'b0010;
      4'b0010: return 4'b0101;
      4'b0101: return 4'b1000;
      default: return 4'b1000;
    endcase
  endfunction

  // Driver: sets inputs for the next edge and queues the predicted lamps.
  task automatic cycle(input logic r, input logic s, input logic [3:0] code,
                       input logic adv, input string tag);
    @(negedge clk);
    rst = r; seedLoad = s; seedCode = code; advance = adv;
    if (r) begin
      modelB = 4'b1000; modelE = 4'b1000;
    end else if (s) begin
      modelB = {code[3:1], 1'b0}; modelE = code;
    end else if (adv) begin
      modelB = basicNext(modelB); modelE = extNext(modelE);
    end
    expB.push_back(modelB[3:1]);
    expE.push_back(modelE[3:1]);
    tagQ.push_back(tag);
  endtask

  // Monitor: compares just after the edge that produced each result.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      while (tagQ.size() > 0) begin
        logic [2:0] wantB, wantE;
        string tag;
        wantB = expB.pop_front();
        wantE = expE.pop_front();
        tag   = tagQ.pop_front();
        checks++;
        if ({bR, bA, bG} !== wantB) begin
          fails++;
          $display("FAIL %s basic: lamps actual %b expected %b", tag, {bR, bA, bG}, wantB);
        end
        checks++;
        if ({eR, eA, eG} !== wantE) begin
          fails++;
          $display("FAIL %s extended: lamps actual %b expected %b", tag, {eR, eA, eG}, wantE);
        end
      end
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung run, expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; seedLoad = 1'b0; advance = 1'b0; seedCode = 4'b0000;
    modelB = 4'b1000; modelE = 4'b1000;
    cycle(1, 0, 4'b0000, 0, "R1 reset");
    cycle(1, 0, 4'b0000, 1, "R1 reset with advance");
    for (int i = 0; i < 8; i++) cycle(0, 0, 4'b0000, 1, "R3 R5 cycle");
    for (int i = 0; i < 3; i++) cycle(0, 0, 4'b0000, 0, "R2 hold");
    cycle(1, 1, 4'b0101, 1, "R1 priority over seed and advance");
    cycle(0, 1, 4'b0110, 1, "R7 seed wins over advance");
    cycle(0, 0, 4'b0000, 0, "R2 hold unused code");
    // Recovery from every raw code, then the full sequence that follows.
    for (int c = 0; c < 16; c++) begin
      cycle(0, 1, 4'(c), 0, "R7 seed");
      cycle(0, 0, 4'b0000, 1, "R4 R6 R8 recovery step");
      for (int k = 0; k < 6; k++) cycle(0, 0, 4'b0000, 1, "R3 R5 R8 sequence");
    end
    for (int i = 0; i < 24; i++) cycle(0, 0, 4'b0000, (i % 3) != 0, "R2 R3 R5 mixed advance");
    cycle(0, 0, 4'b0000, 0, "R2 final hold");
    @(posedge clk);
    #2;
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule